// File: doc/BRIEF.md
# PSRAM Burst Page Splitter

This block sits between a bus-side burst request port and a synchronous PSRAM command generator. A request gives a start byte address, a total length in 4-byte beats and a read/write flag. The block breaks the request into sub-bursts so that no sub-burst crosses a memory page boundary. The page size is set by a 3-bit configuration code. Each sub-burst goes out on a valid/ready handshake as a start address and a beat count. With it come flags that say whether the sub-burst is synchronous and whether the memory wait input must be honoured.

Reads and writes each have their own synchronous-mode enable. A direction whose enable is off runs asynchronously. Its transfer is then handed over one beat at a time and page splitting does not apply. The direction's enable, the page code and the asynchronous wait policy are sampled once, when the request is accepted, and then hold for the whole request.

Back-pressure rules: the downstream side may hold `sub_ready` low for any number of cycles, and the sub-burst fields stay unchanged while they wait. Only one request is in flight at a time. `req_ready` is low from acceptance until the cycle after the last sub-burst has been handed off.

Top module: `psram_page_splitter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1 and `sub_valid` is 0.
- R2: Page code 0, and the reserved codes 5, 6 and 7, disable splitting. A synchronous request is then issued as a single sub-burst carrying the whole length.
- R3: Page codes 1, 2, 3 and 4 select pages of 128, 256, 512 and 1024 bytes. Each synchronous sub-burst carries the smaller of two counts: the beats still owed, and the beats left before the next page boundary. One beat is 4 bytes.
- R4: A write is synchronous (`sub_sync`=1) only when the write-burst enable is 1. A read is synchronous only when the read-burst enable is 1. Each direction ignores the other direction's enable.
- R5: An asynchronous request is issued as one single-beat sub-burst per beat, whatever the page code.
- R6: `sub_use_wait` is 1 only for asynchronous sub-bursts while the async-wait enable is 1. When that enable is 0, or when the sub-burst is synchronous, it is 0.
- R7: `req_ready` is 0 while any sub-burst of the current request is still owed. It returns to 1 in the cycle after the handshake of the sub-burst marked `sub_last`.
- R8: While `sub_valid` is 1 and `sub_ready` is 0, every sub-burst output holds its value.
- R9: The first sub-burst starts at the request address with its two low bits cleared. Each later sub-burst starts where the previous one ended. The beat counts add up to the request length. `sub_last` is 1 only on the final sub-burst.
- R10: The request fields and all configuration inputs are captured at acceptance. Changing them while a request is being split has no effect on its sub-bursts.
- R11: A request of zero beats is accepted and produces no sub-burst. `req_ready` stays 1.
- R12: For a non-zero request, `sub_valid` rises in the cycle right after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page_code | input | 3 | Page-size code (0 none, 1..4 = 128..1024 bytes, 5..7 reserved) |
| cfg_wr_sync_en | input | 1 | Synchronous burst enable for writes |
| cfg_rd_sync_en | input | 1 | Synchronous burst enable for reads |
| cfg_async_wait_en | input | 1 | Honour memory wait during asynchronous transfers |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | ADDR_W | Request start byte address |
| req_beats | input | LEN_W | Request length in 4-byte beats |
| req_write | input | 1 | 1 = write, 0 = read |
| sub_valid | output | 1 | Sub-burst valid |
| sub_ready | input | 1 | Downstream accepts the sub-burst |
| sub_addr | output | ADDR_W | Sub-burst start byte address |
| sub_beats | output | LEN_W | Sub-burst beat count |
| sub_write | output | 1 | Sub-burst direction |
| sub_sync | output | 1 | Sub-burst runs synchronously |
| sub_use_wait | output | 1 | Memory wait input must be honoured |
| sub_last | output | 1 | Final sub-burst of the request |

## Verification
Every result of this block is due exactly one clock edge after its cause. The first sub-burst appears in the cycle after the acceptance edge. Each following sub-burst, or the return of `req_ready`, appears in the cycle after a handshake edge. The bench keeps a behavioural queue of owed sub-bursts and updates it on the rising edge from the handshakes it drives. It compares every output against the head of that queue at the falling edge, so each value is checked in the cycle it is due and in every cycle it is held under back-pressure.

// File: rtl/psram_split_pkg.sv
package psram_split_pkg;
  // bytes per beat, as a shift
  localparam int BEAT_SHIFT = 2;
  // smallest selectable page (log2 bytes) and number of page codes
  localparam int MIN_PAGE_LOG = 7;
  localparam int NUM_PAGE_SIZES = 4;
  localparam int MAX_PAGE_LOG = MIN_PAGE_LOG + NUM_PAGE_SIZES - 1;

  typedef logic [2:0] page_code_t;

  typedef struct packed {
    logic       sync;
    logic       use_wait;
    page_code_t page;
  } xfer_mode_t;

  function automatic logic page_code_valid(page_code_t c);
    return (c != 3'd0) && (int'(c) <= NUM_PAGE_SIZES);
  endfunction
endpackage

// File: rtl/psram_mode_sel.sv
module psram_mode_sel
  import psram_split_pkg::*;
(
  input  logic       is_write,
  input  logic       wr_sync_en,
  input  logic       rd_sync_en,
  input  logic       async_wait_en,
  input  page_code_t page_code,
  output xfer_mode_t mode
);
  logic sync_sel;

  // each direction looks only at its own enable
  assign sync_sel = is_write ? wr_sync_en : rd_sync_en;

  always_comb begin
    mode.sync     = sync_sel;
    mode.use_wait = !sync_sel && async_wait_en;
    // reserved codes and asynchronous transfers collapse to "no split"
    mode.page     = (sync_sel && page_code_valid(page_code)) ? page_code : 3'd0;
  end
endmodule

// File: rtl/psram_page_room.sv
module psram_page_room
  import psram_split_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [MAX_PAGE_LOG-1:BEAT_SHIFT] addr_beat,
  input  logic [LEN_W-1:0]                 remain,
  input  logic                             sync,
  input  page_code_t                       page,
  output logic [LEN_W-1:0]                 beats
);
  localparam int ROOM_W = MAX_PAGE_LOG - BEAT_SHIFT + 1;
  localparam int CMP_W  = (ROOM_W > LEN_W) ? ROOM_W : LEN_W;

  logic [ROOM_W-1:0] room [NUM_PAGE_SIZES];
  logic              hit;
  logic [ROOM_W-1:0] sel_room;

  // beats left before the boundary, one candidate per page size
  genvar g;
  generate
    for (g = 0; g < NUM_PAGE_SIZES; g++) begin : g_size
      localparam int OFF_W = MIN_PAGE_LOG + g - BEAT_SHIFT;
      logic [OFF_W-1:0] off;
      assign off     = addr_beat[BEAT_SHIFT+OFF_W-1:BEAT_SHIFT];
      assign room[g] = ROOM_W'(1 << OFF_W) - ROOM_W'(off);
    end
  endgenerate

  always_comb begin
    hit      = 1'b0;
    sel_room = '0;
    for (int i = 0; i < NUM_PAGE_SIZES; i++) begin
      if (page == page_code_t'(i + 1)) begin
        hit      = 1'b1;
        sel_room = room[i];
      end
    end
  end

  always_comb begin
    if (!sync) begin
      beats = LEN_W'(1);
    end else if (hit && (CMP_W'(sel_room) < CMP_W'(remain))) begin
      beats = LEN_W'(sel_room);
    end else begin
      beats = remain;
    end
  end
endmodule

// File: rtl/psram_split_core.sv
module psram_split_core
  import psram_split_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_beats,
  input  logic              req_write,
  input  xfer_mode_t        req_mode,
  input  logic [LEN_W-1:0]  step_beats,
  input  logic              sub_ready,
  output logic              sub_valid,
  output logic              sub_last,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_remain,
  output logic              cur_write,
  output xfer_mode_t        cur_mode
);
  typedef enum logic {ST_IDLE, ST_ISSUE} split_st_t;

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << BEAT_SHIFT) - 1);

  split_st_t st;

  assign req_ready = (st == ST_IDLE);
  assign sub_valid = (st == ST_ISSUE);
  assign sub_last  = (step_beats == cur_remain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_addr   <= '0;
      cur_remain <= '0;
      cur_write  <= 1'b0;
      cur_mode   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr   <= req_addr & ALIGN_MASK;
            cur_remain <= req_beats;
            cur_write  <= req_write;
            cur_mode   <= req_mode;
            if (req_beats != '0) st <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (sub_ready) begin
            cur_addr   <= cur_addr + (ADDR_W'(step_beats) << BEAT_SHIFT);
            cur_remain <= cur_remain - step_beats;
            if (sub_last) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psram_page_splitter.sv
module psram_page_splitter
  import psram_split_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_page_code,
  input  logic              cfg_wr_sync_en,
  input  logic              cfg_rd_sync_en,
  input  logic              cfg_async_wait_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_beats,
  input  logic              req_write,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [LEN_W-1:0]  sub_beats,
  output logic              sub_write,
  output logic              sub_sync,
  output logic              sub_use_wait,
  output logic              sub_last
);
  xfer_mode_t       req_mode;
  xfer_mode_t       cur_mode;
  logic [LEN_W-1:0] cur_remain;
  logic [LEN_W-1:0] step_beats;

  psram_mode_sel u_mode (
    .is_write      (req_write),
    .wr_sync_en    (cfg_wr_sync_en),
    .rd_sync_en    (cfg_rd_sync_en),
    .async_wait_en (cfg_async_wait_en),
    .page_code     (cfg_page_code),
    .mode          (req_mode)
  );

  psram_split_core #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_beats  (req_beats),
    .req_write  (req_write),
    .req_mode   (req_mode),
    .step_beats (step_beats),
    .sub_ready  (sub_ready),
    .sub_valid  (sub_valid),
    .sub_last   (sub_last),
    .cur_addr   (sub_addr),
    .cur_remain (cur_remain),
    .cur_write  (sub_write),
    .cur_mode   (cur_mode)
  );

  psram_page_room #(.LEN_W(LEN_W)) u_room (
    .addr_beat (sub_addr[MAX_PAGE_LOG-1:BEAT_SHIFT]),
    .remain    (cur_remain),
    .sync      (cur_mode.sync),
    .page      (cur_mode.page),
    .beats     (step_beats)
  );

  assign sub_beats    = step_beats;
  assign sub_sync     = cur_mode.sync;
  assign sub_use_wait = cur_mode.use_wait;
endmodule

// File: rtl/psram_split_chk.sv
module psram_split_chk #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_beats,
  input logic              sub_valid,
  input logic              sub_ready,
  input logic [ADDR_W-1:0] sub_addr,
  input logic [LEN_W-1:0]  sub_beats,
  input logic              sub_write,
  input logic              sub_sync,
  input logic              sub_use_wait,
  input logic              sub_last
);
  // R8
  hold_under_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && !sub_ready |=> sub_valid && $stable(sub_addr) && $stable(sub_beats)
      && $stable(sub_write) && $stable(sub_sync) && $stable(sub_use_wait) && $stable(sub_last));

  // R9
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_ready && !sub_last |=>
      sub_valid && (sub_addr == $past(sub_addr) + (ADDR_W'($past(sub_beats)) << 2)));

  // R7
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_ready && sub_last |=> req_ready);

  // R7
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> !req_ready);

  // R5
  async_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && !sub_sync |-> sub_beats == LEN_W'(1));

  // R6
  sync_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_sync |-> !sub_use_wait);

  // R12
  issue_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_beats != '0) |=> sub_valid);

  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_beats == '0) |=> req_ready && !sub_valid);

  // R3
  nonzero_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> sub_beats != '0);
endmodule

bind psram_page_splitter psram_split_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_beats    (req_beats),
  .sub_valid    (sub_valid),
  .sub_ready    (sub_ready),
  .sub_addr     (sub_addr),
  .sub_beats    (sub_beats),
  .sub_write    (sub_write),
  .sub_sync     (sub_sync),
  .sub_use_wait (sub_use_wait),
  .sub_last     (sub_last)
);

// File: tb/sim_psram_page_splitter.sv
module sim_psram_page_splitter;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        cfg_page_code = 3'd0;
  logic              cfg_wr_sync_en = 1'b0;
  logic              cfg_rd_sync_en = 1'b0;
  logic              cfg_async_wait_en = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_beats = '0;
  logic              req_write = 1'b0;
  logic              sub_valid;
  logic              sub_ready = 1'b1;
  logic [ADDR_W-1:0] sub_addr;
  logic [LEN_W-1:0]  sub_beats;
  logic              sub_write;
  logic              sub_sync;
  logic              sub_use_wait;
  logic              sub_last;

  always #5 clk = ~clk;

  psram_page_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (.*);

  typedef struct {
    int addr;
    int beats;
    bit sync;
    bit wt;
    bit last;
    bit wr;
  } sub_t;

  sub_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  int   cycles = 0;
  bit   bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // behavioural split of one request, config read at the acceptance edge
  function automatic void gen(int addr, int beats, bit wr);
    bit sync;
    int a, rem, psz, n;
    sub_t e;
    sync = wr ? cfg_wr_sync_en : cfg_rd_sync_en;
    a    = addr & 32'hFFFFFC;
    rem  = beats;
    psz  = 0;
    if (sync && cfg_page_code >= 3'd1 && cfg_page_code <= 3'd4) psz = 64 << cfg_page_code;
    while (rem > 0) begin
      if (!sync) n = 1;
      else if (psz != 0) begin
        n = (psz - (a % psz)) / 4;
        if (n > rem) n = rem;
      end else n = rem;
      e.addr  = a;
      e.beats = n;
      e.sync  = sync;
      e.wt    = !sync && cfg_async_wait_en;
      e.last  = (n == rem);
      e.wr    = wr;
      q.push_back(e);
      a   = (a + 4 * n) & 32'hFFFFFF;
      rem = rem - n;
    end
  endfunction

  // reference model advances on the rising edge
  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else if (q.size() != 0) begin
      if (sub_ready) void'(q.pop_front());
    end else if (req_valid) begin
      gen(int'(req_addr), int'(req_beats), req_write);
    end
  end

  // comparison, back-pressure pattern and watchdog on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R7 req_ready", int'(req_ready), int'(q.size() == 0));
      chk("R12 sub_valid", int'(sub_valid), int'(q.size() != 0));
      if (q.size() != 0 && sub_valid) begin
        chk("R9 sub_addr", int'(sub_addr), q[0].addr);
        chk("R2/R3/R5 sub_beats", int'(sub_beats), q[0].beats);
        chk("R4 sub_sync", int'(sub_sync), int'(q[0].sync));
        chk("R6 sub_use_wait", int'(sub_use_wait), int'(q[0].wt));
        chk("R9 sub_last", int'(sub_last), int'(q[0].last));
        chk("R10 sub_write", int'(sub_write), int'(q[0].wr));
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sub_ready = bp_on ? lfsr[0] : 1'b1;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic run_req(int addr, int beats, bit wr, bit mutate);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_beats = LEN_W'(beats);
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (mutate) begin
      // R10: disturb request and config while the split runs
      req_addr          = ~req_addr;
      req_beats         = 8'd3;
      req_write         = ~wr;
      cfg_page_code     = 3'd1;
      cfg_wr_sync_en    = ~cfg_wr_sync_en;
      cfg_rd_sync_en    = ~cfg_rd_sync_en;
      cfg_async_wait_en = ~cfg_async_wait_en;
    end
    while (q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  task automatic set_cfg(int code, bit wr_en, bit rd_en, bit aw);
    cfg_page_code     = 3'(code);
    cfg_wr_sync_en    = wr_en;
    cfg_rd_sync_en    = rd_en;
    cfg_async_wait_en = aw;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk("R1 req_ready in reset", int'(req_ready), 1);
    chk("R1 sub_valid in reset", int'(sub_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready after reset", int'(req_ready), 1);
    chk("R1 sub_valid after reset", int'(sub_valid), 0);

    // R2: no split with code 0
    set_cfg(0, 0, 1, 0);
    run_req(32'h100, 20, 0, 0);
    // R3: 128-byte pages, crosses twice
    set_cfg(1, 0, 1, 0);
    run_req(32'h070, 40, 0, 0);
    // R3: 1024-byte pages
    set_cfg(4, 1, 0, 0);
    run_req(32'h3F8, 10, 1, 0);
    // R3: 256 and 512-byte pages
    set_cfg(2, 1, 1, 0);
    run_req(32'h1F0, 200, 1, 0);
    set_cfg(3, 1, 1, 1);
    run_req(32'h5FC, 255, 0, 0);
    // R2: reserved codes behave as no split
    set_cfg(6, 1, 0, 0);
    run_req(32'h07C, 50, 1, 0);
    set_cfg(7, 0, 1, 0);
    run_req(32'h0FC, 9, 0, 0);
    // R4/R5/R6: write enable off, wait honoured
    set_cfg(1, 0, 1, 1);
    run_req(32'h07C, 3, 1, 0);
    // R4/R6: read enable off, write enable on, wait ignored
    set_cfg(1, 1, 0, 0);
    run_req(32'h200, 4, 0, 0);
    // R9: unaligned start address has its low bits cleared
    set_cfg(1, 1, 1, 0);
    run_req(32'h103, 30, 0, 0);
    // R11: zero-length request
    run_req(32'h400, 0, 1, 0);
    // R8: back-pressure on the sub-burst port
    bp_on = 1'b1;
    set_cfg(1, 1, 1, 0);
    run_req(32'h060, 100, 1, 0);
    set_cfg(0, 0, 0, 1);
    run_req(32'h010, 6, 0, 0);
    // R10: captured settings survive changes mid-split
    set_cfg(1, 1, 1, 0);
    run_req(32'h0F0, 60, 0, 1);
    set_cfg(2, 0, 1, 1);
    run_req(32'hFFFFF0, 12, 0, 0);
    bp_on = 1'b0;
    // back-to-back requests with full throughput
    set_cfg(4, 1, 1, 0);
    for (int i = 0; i < 8; i++) run_req(32'h3C0 + i * 64, 5 + i * 20, i[0], 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule